// File: doc/BRIEF.md
# Two-Source Interrupt and Halt Controller

This block sequences the interrupt and power-down behaviour of a small 4-bit controller core whose return stack holds exactly one entry of 13 bits (a 12-bit program address plus the carry flag). It takes two interrupt sources: a timer overflow request, and a real-time tick. The tick is made inside the block by dividing a base strobe by a power of two. Each source has its own pending latch. When interrupts are enabled and the core is running outside any subroutine, the block raises a one-cycle vector-load request together with the target address. The tick always has priority over the timer.

Because the stack has a single slot, a request is never granted while a called subroutine or a service routine is active. The core drives the block with single-cycle strobes for enable, disable, call, return, return-from-interrupt and halt. The block answers with stack push/pop controls and carry save/restore controls. It also keeps a halted state that stops the core clock, and it produces a wake pulse. The wake rule depends on the enable state. A tick that arrives while interrupts are off wakes the core and stays pending. A tick that arrives while interrupts are on wakes the core and is serviced on the next cycle. A masked falling edge on an input pin also wakes the core.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all outputs are low. Interrupts start disabled and nothing is pending.
- R2: A pending tick request vectors to address 8 and a pending timer request vectors to address 4. vec_load_o rises in the cycle after the request is latched, provided interrupts are enabled, the context is the main program and the core is not halted.
- R3: When both requests are pending, the tick is granted first and the timer request is granted after the following return-from-interrupt. This holds whatever the order of arrival.
- R4: Interrupts are disabled after reset and after di_i, and requests stay pending. The first grant can occur in the cycle after ei_i. If di_i and ei_i arrive together, di_i wins.
- R5: After call_i, no request is granted until ret_i. A held request is granted in the cycle after ret_i.
- R6: A grant enters the service context. No further grant occurs until reti_i, so there are never two vector loads in consecutive cycles.
- R7: push_carry_o is high exactly with a vector load. stack_push_o is high on call_i or on a vector load. stack_pop_o is high on ret_i or reti_i. pop_carry_o is high only on reti_i.
- R8: A grant clears the granted source's pending latch. A new request from that same source in the grant cycle is latched again and granted after the next reti_i.
- R9: The tick fires on every 2^RTC_SHIFT-th base strobe, counted from reset (the default is every 4th strobe).
- R10: After halt_i, halted_o is high from the next cycle and no vector load occurs. If a tick arrives with interrupts disabled, wake_o pulses in that cycle and halted_o drops in the next cycle. The tick stays pending and is granted in the cycle after ei_i.
- R11: If a tick arrives during halt with interrupts enabled, wake_o pulses, halted_o drops, and the vector load to address 8 occurs in the next cycle.
- R12: During halt, a high-to-low change on pin bit k with wake_mask_i[k]=1 pulses wake_o in that cycle. A falling edge on a bit whose mask is 0, a rising edge, and any pin or tick activity while not halted all leave wake_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_req_i | input | 1 | Timer overflow request strobe |
| rtc_base_i | input | 1 | Base strobe for the tick divider |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Plain return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| halt_i | input | 1 | Halt command strobe |
| pin_i | input | N_PINS | Input pin levels (idle high) |
| wake_mask_i | input | N_PINS | Per-pin wake enable |
| vec_load_o | output | 1 | Load vector address into PC |
| vec_addr_o | output | PC_W | Vector target address |
| halted_o | output | 1 | Core clock stopped |
| wake_o | output | 1 | Wake pulse out of halt |
| push_carry_o | output | 1 | Save carry into stack slot |
| pop_carry_o | output | 1 | Restore carry from stack slot |
| stack_push_o | output | 1 | Write PC into stack slot |
| stack_pop_o | output | 1 | Restore PC from stack slot |

## Verification
The hardest case to reach is two requests pending at the same moment while a grant is impossible. This is the only way to see the tick win over a timer request that arrived earlier. The stimulus disables interrupts, raises the timer request first, and then feeds four base strobes so that the divided tick appears afterwards. Only then does it enable interrupts and watch the two grants across the intervening return-from-interrupt. A similar approach sets up the disabled-halt wake: halt is entered with interrupts off, and the pending tick is kept visible only through the vector that follows the later enable.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  typedef enum logic [1:0] {
    CTX_MAIN = 2'd0,
    CTX_CALL = 2'd1,
    CTX_ISR  = 2'd2
  } ctx_e;
endpackage

// File: rtl/irq_rtc_div.sv
module irq_rtc_div #(
  parameter int unsigned SHIFT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_i,
  output logic tick_o
);
  localparam int unsigned CW = (SHIFT > 0) ? SHIFT : 1;
  localparam logic [CW-1:0] LAST = CW'((1 << SHIFT) - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = base_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (base_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] mask_i,
  output logic         fall_o
);
  logic [N-1:0] prev_q;

  // pins idle high, so reset history to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= pin_i;
  end

  assign fall_o = |(prev_q & ~pin_i & mask_i);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned PC_W    = 12,
  parameter int unsigned TMR_VEC = 4,
  parameter int unsigned RTC_VEC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tmr_set_i,
  input  logic            rtc_set_i,
  input  logic            grant_en_i,
  output logic            take_o,
  output logic [PC_W-1:0] addr_o,
  output logic            rtc_pend_o,
  output logic            tmr_pend_o
);
  logic rtc_q, tmr_q;
  logic pick_rtc;

  assign pick_rtc = rtc_q;
  assign take_o   = grant_en_i && (rtc_q || tmr_q);
  assign addr_o   = pick_rtc ? PC_W'(RTC_VEC) : PC_W'(TMR_VEC);

  // set wins over the grant clear so a same-cycle request is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtc_q <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      rtc_q <= rtc_set_i || (rtc_q && !(take_o && pick_rtc));
      tmr_q <= tmr_set_i || (tmr_q && !(take_o && !pick_rtc));
    end
  end

  assign rtc_pend_o = rtc_q;
  assign tmr_pend_o = tmr_q;
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irq_halt_pkg::*;
#(
  parameter int unsigned PC_W      = 12,
  parameter int unsigned N_PINS    = 7,
  parameter int unsigned RTC_SHIFT = 2,
  parameter int unsigned TMR_VEC   = 4,
  parameter int unsigned RTC_VEC   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_req_i,
  input  logic              rtc_base_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              reti_i,
  input  logic              halt_i,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] wake_mask_i,
  output logic              vec_load_o,
  output logic [PC_W-1:0]   vec_addr_o,
  output logic              halted_o,
  output logic              wake_o,
  output logic              push_carry_o,
  output logic              pop_carry_o,
  output logic              stack_push_o,
  output logic              stack_pop_o
);
  logic ie_q, halted_q;
  ctx_e ctx_q;
  logic rtc_evt, pin_fall, take, grant_en;
  logic rtc_pend, tmr_pend;

  irq_rtc_div #(.SHIFT(RTC_SHIFT)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (rtc_base_i),
    .tick_o (rtc_evt)
  );

  irq_wake_det #(.N(N_PINS)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .mask_i (wake_mask_i),
    .fall_o (pin_fall)
  );

  assign grant_en = ie_q && (ctx_q == CTX_MAIN) && !halted_q;

  irq_arbiter #(.PC_W(PC_W), .TMR_VEC(TMR_VEC), .RTC_VEC(RTC_VEC)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmr_set_i  (tmr_req_i),
    .rtc_set_i  (rtc_evt),
    .grant_en_i (grant_en),
    .take_o     (take),
    .addr_o     (vec_addr_o),
    .rtc_pend_o (rtc_pend),
    .tmr_pend_o (tmr_pend)
  );

  assign wake_o = halted_q && (rtc_evt || pin_fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q     <= 1'b0;
      ctx_q    <= CTX_MAIN;
      halted_q <= 1'b0;
    end else begin
      if (di_i)      ie_q <= 1'b0;
      else if (ei_i) ie_q <= 1'b1;

      if (take)                 ctx_q <= CTX_ISR;
      else if (call_i)          ctx_q <= CTX_CALL;
      else if (ret_i || reti_i) ctx_q <= CTX_MAIN;

      if (!halted_q && halt_i) halted_q <= 1'b1;
      else if (wake_o)         halted_q <= 1'b0;
    end
  end

  assign vec_load_o   = take;
  assign halted_o     = halted_q;
  assign push_carry_o = take;
  assign pop_carry_o  = reti_i;
  assign stack_push_o = take || call_i;
  assign stack_pop_o  = ret_i || reti_i;
endmodule

// File: rtl/irq_halt_ctrl_chk.sv
module irq_halt_ctrl_chk #(
  parameter int unsigned PC_W    = 12,
  parameter int unsigned TMR_VEC = 4,
  parameter int unsigned RTC_VEC = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            di_i,
  input logic            call_i,
  input logic            halt_i,
  input logic            vec_load_o,
  input logic [PC_W-1:0] vec_addr_o,
  input logic            halted_o,
  input logic            wake_o,
  input logic            rtc_pend_i
);
  assert_vec_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_o |-> (vec_addr_o == PC_W'(RTC_VEC) || vec_addr_o == PC_W'(TMR_VEC)));

  assert_rtc_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_load_o && rtc_pend_i) |-> vec_addr_o == PC_W'(RTC_VEC));

  assert_di_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !vec_load_o);

  assert_call_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> !vec_load_o);

  assert_no_nest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_o |=> !vec_load_o);

  assert_halt_enter_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !halted_o && !wake_o) |=> halted_o);

  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !vec_load_o);

  assert_wake_in_halt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> halted_o);

  assert_wake_exits_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !halted_o);
endmodule

bind irq_halt_ctrl irq_halt_ctrl_chk #(
  .PC_W(PC_W), .TMR_VEC(TMR_VEC), .RTC_VEC(RTC_VEC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .di_i       (di_i),
  .call_i     (call_i),
  .halt_i     (halt_i),
  .vec_load_o (vec_load_o),
  .vec_addr_o (vec_addr_o),
  .halted_o   (halted_o),
  .wake_o     (wake_o),
  .rtc_pend_i (rtc_pend)
);

// File: tb/irq_halt_ctrl_bench.sv
module irq_halt_ctrl_bench;
  localparam int unsigned PC_W = 12;
  localparam int unsigned NP   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr, base, ei, di, call, ret, reti, halt;
  logic [NP-1:0] pins = '1;
  logic [NP-1:0] mask = 7'b0000100;
  logic vl, hlt, wk, pc, pp, spush, spop;
  logic [PC_W-1:0] addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_halt_ctrl u_irq_halt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tmr_req_i(tmr), .rtc_base_i(base),
    .ei_i(ei), .di_i(di), .call_i(call), .ret_i(ret), .reti_i(reti),
    .halt_i(halt), .pin_i(pins), .wake_mask_i(mask),
    .vec_load_o(vl), .vec_addr_o(addr), .halted_o(hlt), .wake_o(wk),
    .push_carry_o(pc), .pop_carry_o(pp), .stack_push_o(spush), .stack_pop_o(spop)
  );

  // stim: tmr base ei di call ret reti halt | exp: vl a8 hlt wk pc pp
  localparam int NROWS = 22;
  localparam logic [13:0] TBL [NROWS] = '{
    14'b10000000_000000, // R4 timer latched, interrupts off
    14'b00000000_000000, // R4 held
    14'b00100000_000000, // R4 enable
    14'b00000000_100010, // R2 timer vector 4, carry pushed R7
    14'b00000000_000000, // R6 in service
    14'b10000000_000000, // R6 new request during service
    14'b00000000_000000, // R6 still held
    14'b00000010_000001, // R7 reti restores carry
    14'b00000000_100010, // R6 held request granted
    14'b00000010_000001,
    14'b00001000_000000, // R5 call
    14'b10000000_000000, // R5 request inside call
    14'b00000000_000000, // R5 held
    14'b00000100_000000, // R5 ret, no carry restore R7
    14'b10000000_100010, // R8 request in grant cycle
    14'b00000010_000001,
    14'b00000000_100010, // R8 relatched request granted
    14'b00000010_000001,
    14'b00000000_000000, // R8 nothing left
    14'b00010000_000000, // R4 disable
    14'b10000000_000000,
    14'b00000000_000000  // R4 held while disabled
  };

  task automatic step(input logic [7:0] s, input logic [NP-1:0] p);
    @(negedge clk);
    {tmr, base, ei, di, call, ret, reti, halt} = s;
    pins = p;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  localparam logic [7:0] IDLE = 8'b00000000;
  localparam logic [7:0] BASE = 8'b01000000;
  localparam logic [7:0] EI   = 8'b00100000;
  localparam logic [7:0] DI   = 8'b00010000;
  localparam logic [7:0] CALL = 8'b00001000;
  localparam logic [7:0] RET  = 8'b00000100;
  localparam logic [7:0] RETI = 8'b00000010;
  localparam logic [7:0] HALT = 8'b00000001;
  localparam logic [7:0] TMR  = 8'b10000000;
  localparam logic [NP-1:0] HI = '1;

  function automatic logic [5:0] obs();
    return {vl, vl && (addr == PC_W'(8)), hlt, wk, pc, pp};
  endfunction

  task automatic do_reset();
    {tmr, base, ei, di, call, ret, reti, halt} = '0;
    pins = HI;
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 outputs in reset", {26'd0, obs()}, 32'd0);
    check("R1 stack ctl in reset", {30'd0, spush, spop}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 outputs after reset", {26'd0, obs()}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NROWS; i++) begin
      step(TBL[i][13:6], HI);
      check($sformatf("table row %0d (R2 R4 R5 R6 R7 R8)", i),
            {26'd0, obs()}, {26'd0, TBL[i][5:0]});
    end

    do_reset();
    // R7 stack controls
    step(CALL, HI);
    check("R7 call pushes", {30'd0, spush, pc}, 32'd2);
    step(RET, HI);
    check("R7 ret pops without carry", {30'd0, spop, pp}, 32'd2);
    step(RETI, HI);
    check("R7 reti pops with carry", {30'd0, spop, pp}, 32'd3);

    // R9 divider and R10 wake with interrupts off
    step(HALT, HI);
    check("R10 halt not yet", {31'd0, hlt}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      step(BASE, HI);
      check("R9 no tick before 4th strobe", {30'd0, hlt, wk}, 32'd2);
    end
    step(BASE, HI);
    check("R9 tick on 4th strobe wakes", {30'd0, hlt, wk}, 32'd3);
    step(IDLE, HI);
    check("R10 awake, no vector while disabled", {30'd0, hlt, vl}, 32'd0);
    step(EI, HI);
    check("R10 still held at enable", {31'd0, vl}, 32'd0);
    step(IDLE, HI);
    check("R10 kept tick granted to 8", {26'd0, obs()}, 32'b110010);
    step(RETI, HI);

    // R3 priority: timer first, tick later
    step(DI, HI);
    step(TMR, HI);
    check("R4 no grant while disabled", {31'd0, vl}, 32'd0);
    for (int k = 0; k < 4; k++) step(BASE, HI);
    check("R12 tick outside halt gives no wake", {31'd0, wk}, 32'd0);
    step(EI, HI);
    check("R3 nothing at enable", {31'd0, vl}, 32'd0);
    step(IDLE, HI);
    check("R3 tick granted first", {20'd0, vl, addr[10:0]}, {20'd0, 1'b1, 11'd8});
    step(RETI, HI);
    step(IDLE, HI);
    check("R3 timer granted second", {20'd0, vl, addr[10:0]}, {20'd0, 1'b1, 11'd4});
    step(RETI, HI);
    step(IDLE, HI);
    check("R3 none left", {31'd0, vl}, 32'd0);

    // R11 wake with interrupts on
    step(HALT, HI);
    for (int k = 0; k < 3; k++) step(BASE, HI);
    check("R11 halted before tick", {30'd0, hlt, wk}, 32'd2);
    step(BASE, HI);
    check("R11 wake pulse", {31'd0, wk}, 32'd1);
    step(IDLE, HI);
    check("R11 immediate vector 8", {26'd0, obs()}, 32'b110010);
    step(RETI, HI);

    // R12 pin wake
    step(HALT, HI);
    step(IDLE, 7'b1111110);
    check("R12 masked-off pin ignored", {30'd0, hlt, wk}, 32'd2);
    step(IDLE, HI);
    step(IDLE, 7'b1111011);
    check("R12 enabled pin falling wakes", {30'd0, hlt, wk}, 32'd3);
    step(IDLE, 7'b1111011);
    check("R12 awake after pin wake", {30'd0, hlt, vl}, 32'd0);
    step(HALT, 7'b1111011);
    step(IDLE, HI);
    check("R12 rising edge ignored", {30'd0, hlt, wk}, 32'd2);
    step(IDLE, 7'b1111011);
    check("R12 second fall wakes", {31'd0, wk}, 32'd1);
    step(IDLE, HI);
    step(IDLE, 7'b1111011);
    check("R12 fall outside halt ignored", {30'd0, hlt, wk}, 32'd0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule